// File: doc/BRIEF.md
# Paged Address Translator with Associative Cache

This block turns logical addresses into physical addresses for a single requester. A logical address is split into a page number (upper bits) and an in-page offset (lower bits). The page number is looked up in a small fully associative translation cache. On a hit the frame number comes back at once. On a miss the block reads one page-table entry from memory through a simple read port, and then answers. The entry's address is the table base register plus the page number.

Each page-table entry holds a frame number, a presence flag and a write-permission flag. A request whose page number is at or beyond the table length register traps before any memory is touched. An absent page traps. A write to a page without write permission traps. Every write that does not fault marks its page as modified in a per-page flag vector, which is visible at the ports. Loading a new table base empties the translation cache and clears the modified flags, so switching tables costs one register write. A request is taken only while no miss is pending, and exactly one response follows each request.

Top module: `pgxlat_unit`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, mem_valid is 0, page_mod is all zero, and the table length register is 0, so every access traps on length until the length is written.
- R2: The page number is req_addr[VA_W-1:OFF_W] and the offset is req_addr[OFF_W-1:0]. A response without a fault carries rsp_paddr = {frame, offset}. A faulting response carries rsp_paddr = 0.
- R3: On a miss, mem_addr equals table base + page number, truncated to MADDR_W bits. mem_valid stays high, with mem_addr stable, until the cycle in which mem_ready is high.
- R4: A cache hit gives rsp_valid in the cycle right after the accepting clock edge, with no memory read. On a miss, rsp_valid is high in the cycle right after the mem_valid and mem_ready handshake edge.
- R5: A page number greater than or equal to the length register gives rsp_fault = 1 in the next cycle, and no memory read is made.
- R6: A fetched entry with its presence flag (bit FRAME_W) clear gives rsp_fault = 2.
- R7: A write whose fetched entry has the write-permission flag (bit FRAME_W+1) clear gives rsp_fault = 3. A read of that page does not fault. rsp_fault = 0 means no fault.
- R8: A faulting fetch does not load the cache, so the next access to that page reads memory again.
- R9: Writing the table base invalidates every cache entry, resets the replacement pointer to slot 0, and clears page_mod.
- R10: Cache slots are filled round-robin. After TLB_N+1 distinct fills, the first page filled misses again and the others still hit.
- R11: A write without a fault sets page_mod[page] from the cycle its response appears. Reads and faulting writes leave page_mod unchanged.
- R12: A hit keeps the cached write permission: a write that hits a read-only page gives rsp_fault = 3 without a memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbase_we | input | 1 | Load table base register |
| tbase_wdata | input | MADDR_W | New table base |
| tlen_we | input | 1 | Load table length register |
| tlen_wdata | input | VPN_W+1 | New table length in pages |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | VA_W | Logical address |
| req_write | input | 1 | 1 for a write access |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_fault | output | 2 | 0 none, 1 length, 2 absent, 3 write-protect |
| rsp_paddr | output | FRAME_W+OFF_W | Physical address |
| mem_valid | output | 1 | Entry read request |
| mem_ready | input | 1 | Memory returns data this cycle |
| mem_addr | output | MADDR_W | Entry address |
| mem_rdata | input | FRAME_W+2 | Entry: [FRAME_W+1] writable, [FRAME_W] present, frame below |
| page_mod | output | 2**VPN_W | Per-page modified flags |

## Verification
The bench first runs directed sequences. A miss followed by a hit to the same page separates the two latencies. Accesses at and just below the length separate the boundary. Absent and read-only entries, read with both access types, separate the three fault codes, and repeat accesses then show whether a fault loaded the cache. Five distinct pages, then the first again, show the round-robin eviction, and a base write in mid-stream shows the flush. Random addresses, access types, page tables, bases, lengths and memory latencies then test everything against a bench model of the cache and the modified flags. That run catches wrong hit or miss decisions, wrong entry addresses and wrong modified-flag updates that the directed cases do not reach.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_LEN  = 2'd1,
      FLT_ABS  = 2'd2,
      FLT_WP   = 2'd3
   } pgx_fault_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WALK = 1'b1
   } pgx_state_e;
endpackage

// File: rtl/pgx_pte_chk.sv
module pgx_pte_chk
   import pgx_pkg::*;
#(
   parameter int FRAME_W = 8
) (
   input  logic [FRAME_W+1:0] pte,
   input  logic               is_write,
   output logic [FRAME_W-1:0] frame,
   output logic               writable,
   output pgx_fault_e         fault
);
   localparam int PRES_BIT = FRAME_W;
   localparam int WR_BIT   = FRAME_W + 1;

   always_comb begin
      frame    = pte[FRAME_W-1:0];
      writable = pte[WR_BIT];
      if (!pte[PRES_BIT])
         fault = FLT_ABS;
      else if (is_write && !pte[WR_BIT])
         fault = FLT_WP;
      else
         fault = FLT_NONE;
   end
endmodule

// File: rtl/pgx_tlb.sv
module pgx_tlb #(
   parameter int N       = 4,
   parameter int TAG_W   = 3,
   parameter int FRAME_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic [TAG_W-1:0]   lk_tag,
   output logic               lk_hit,
   output logic [FRAME_W-1:0] lk_frame,
   output logic               lk_wr,
   input  logic               fill_en,
   input  logic [TAG_W-1:0]   fill_tag,
   input  logic [FRAME_W-1:0] fill_frame,
   input  logic               fill_wr
);
   localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

   if (N < 2) begin : g_bad_n
      $error("pgx_tlb: N must be at least 2");
   end
   if (TAG_W < 1 || FRAME_W < 1) begin : g_bad_w
      $error("pgx_tlb: widths must be positive");
   end

   logic [N-1:0]       ent_v;
   logic [TAG_W-1:0]   ent_tag   [N];
   logic [FRAME_W-1:0] ent_frame [N];
   logic [N-1:0]       ent_wr;
   logic [N-1:0]       hit_vec;
   logic [PTR_W-1:0]   rr_ptr;

   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign hit_vec[i] = ent_v[i] && (ent_tag[i] == lk_tag);
   end

   always_comb begin
      lk_hit   = 1'b0;
      lk_frame = '0;
      lk_wr    = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (hit_vec[i]) begin
            lk_hit   = 1'b1;
            lk_frame = lk_frame | ent_frame[i];
            lk_wr    = lk_wr | ent_wr[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_v  <= '0;
         ent_wr <= '0;
         rr_ptr <= '0;
         for (int i = 0; i < N; i++) begin
            ent_tag[i]   <= '0;
            ent_frame[i] <= '0;
         end
      end else if (flush) begin
         ent_v  <= '0;
         rr_ptr <= '0;
      end else if (fill_en) begin
         for (int i = 0; i < N; i++) begin
            if (rr_ptr == PTR_W'(i)) begin
               ent_v[i]     <= 1'b1;
               ent_tag[i]   <= fill_tag;
               ent_frame[i] <= fill_frame;
               ent_wr[i]    <= fill_wr;
            end
         end
         rr_ptr <= (rr_ptr == PTR_W'(N - 1)) ? '0 : rr_ptr + 1'b1;
      end
   end

   // no page is ever held twice (round-robin fill only on miss)
   assert_unique_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (ent_v == '0));
endmodule

// File: rtl/pgx_dirty.sv
module pgx_dirty #(
   parameter int NPAGE = 8,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             set_en,
   input  logic [IDX_W-1:0] set_idx,
   output logic [NPAGE-1:0] bits
);
   if (NPAGE != (1 << IDX_W)) begin : g_bad_np
      $error("pgx_dirty: NPAGE must equal 2**IDX_W");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         bits <= '0;
      else if (clr)
         bits <= '0;
      else if (set_en)
         bits[set_idx] <= 1'b1;
   end

   assert_mark_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && !clr) |=> bits[$past(set_idx)]);

   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (bits == '0));
endmodule

// File: rtl/pgxlat_unit.sv
module pgxlat_unit
   import pgx_pkg::*;
#(
   parameter int VA_W    = 14,
   parameter int OFF_W   = 11,
   parameter int FRAME_W = 8,
   parameter int TLB_N   = 4,
   parameter int MADDR_W = 8,
   localparam int VPN_W  = VA_W - OFF_W,
   localparam int NPAGE  = 1 << VPN_W,
   localparam int PTE_W  = FRAME_W + 2,
   localparam int PA_W   = FRAME_W + OFF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tbase_we,
   input  logic [MADDR_W-1:0] tbase_wdata,
   input  logic               tlen_we,
   input  logic [VPN_W:0]     tlen_wdata,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [VA_W-1:0]    req_addr,
   input  logic               req_write,
   output logic               rsp_valid,
   output logic [1:0]         rsp_fault,
   output logic [PA_W-1:0]    rsp_paddr,
   output logic               mem_valid,
   input  logic               mem_ready,
   output logic [MADDR_W-1:0] mem_addr,
   input  logic [PTE_W-1:0]   mem_rdata,
   output logic [NPAGE-1:0]   page_mod
);
   if (OFF_W < 1 || OFF_W >= VA_W) begin : g_bad_off
      $error("pgxlat_unit: OFF_W must lie in 1..VA_W-1");
   end
   if (MADDR_W < VPN_W) begin : g_bad_maddr
      $error("pgxlat_unit: MADDR_W must cover the page number");
   end

   pgx_state_e          st;
   logic [MADDR_W-1:0]  tbase_q;
   logic [VPN_W:0]      tlen_q;
   logic [VPN_W-1:0]    vpn_q;
   logic [OFF_W-1:0]    off_q;
   logic                wr_q;
   logic [MADDR_W-1:0]  maddr_q;

   logic [VPN_W-1:0]    vpn_in;
   logic [OFF_W-1:0]    off_in;
   logic                accept;
   logic                len_bad;
   logic                lk_hit;
   logic [FRAME_W-1:0]  lk_frame;
   logic                lk_wr;
   logic                walk_done;
   logic [FRAME_W-1:0]  chk_frame;
   logic                chk_wr;
   pgx_fault_e          chk_fault;
   logic                fill_en;
   logic                hit_ok;
   logic                mark_en;
   logic [VPN_W-1:0]    mark_idx;

   assign vpn_in    = req_addr[VA_W-1:OFF_W];
   assign off_in    = req_addr[OFF_W-1:0];
   assign req_ready = (st == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign len_bad   = ({1'b0, vpn_in} >= tlen_q);
   assign mem_valid = (st == ST_WALK);
   assign mem_addr  = maddr_q;
   assign walk_done = mem_valid && mem_ready;

   pgx_tlb #(
      .N       (TLB_N),
      .TAG_W   (VPN_W),
      .FRAME_W (FRAME_W)
   ) u_tlb (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (tbase_we),
      .lk_tag     (vpn_in),
      .lk_hit     (lk_hit),
      .lk_frame   (lk_frame),
      .lk_wr      (lk_wr),
      .fill_en    (fill_en),
      .fill_tag   (vpn_q),
      .fill_frame (chk_frame),
      .fill_wr    (chk_wr)
   );

   pgx_pte_chk #(
      .FRAME_W (FRAME_W)
   ) u_chk (
      .pte      (mem_rdata),
      .is_write (wr_q),
      .frame    (chk_frame),
      .writable (chk_wr),
      .fault    (chk_fault)
   );

   assign fill_en = walk_done && (chk_fault == FLT_NONE);
   assign hit_ok  = accept && !len_bad && lk_hit && (!req_write || lk_wr);

   always_comb begin
      mark_en  = 1'b0;
      mark_idx = vpn_in;
      if (hit_ok && req_write) begin
         mark_en  = 1'b1;
         mark_idx = vpn_in;
      end else if (fill_en && wr_q) begin
         mark_en  = 1'b1;
         mark_idx = vpn_q;
      end
   end

   pgx_dirty #(
      .NPAGE (NPAGE),
      .IDX_W (VPN_W)
   ) u_mod (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (tbase_we),
      .set_en  (mark_en),
      .set_idx (mark_idx),
      .bits    (page_mod)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tbase_q <= '0;
         tlen_q  <= '0;
      end else begin
         if (tbase_we) tbase_q <= tbase_wdata;
         if (tlen_we)  tlen_q  <= tlen_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         rsp_valid <= 1'b0;
         rsp_fault <= FLT_NONE;
         rsp_paddr <= '0;
         vpn_q     <= '0;
         off_q     <= '0;
         wr_q      <= 1'b0;
         maddr_q   <= '0;
      end else begin
         rsp_valid <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (accept) begin
                  vpn_q <= vpn_in;
                  off_q <= off_in;
                  wr_q  <= req_write;
                  if (len_bad) begin
                     rsp_valid <= 1'b1;
                     rsp_fault <= FLT_LEN;
                     rsp_paddr <= '0;
                  end else if (lk_hit) begin
                     rsp_valid <= 1'b1;
                     if (req_write && !lk_wr) begin
                        rsp_fault <= FLT_WP;
                        rsp_paddr <= '0;
                     end else begin
                        rsp_fault <= FLT_NONE;
                        rsp_paddr <= {lk_frame, off_in};
                     end
                  end else begin
                     st      <= ST_WALK;
                     maddr_q <= tbase_q + {{(MADDR_W-VPN_W){1'b0}}, vpn_in};
                  end
               end
            end
            ST_WALK: begin
               if (mem_ready) begin
                  st        <= ST_IDLE;
                  rsp_valid <= 1'b1;
                  rsp_fault <= chk_fault;
                  rsp_paddr <= (chk_fault == FLT_NONE) ? {chk_frame, off_q} : '0;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assert_len_trap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && len_bad) |=> (rsp_valid && rsp_fault == FLT_LEN && !mem_valid));

   assert_mem_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

   assert_hit_fast_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !len_bad && lk_hit) |=> (rsp_valid && !mem_valid));

   assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault == FLT_NONE) |-> (rsp_paddr[OFF_W-1:0] == off_q));

   assert_walk_answers_R4: assert property (@(posedge clk) disable iff (!rst_n)
      walk_done |=> (rsp_valid && req_ready));
endmodule

// File: tb/tb_pgxlat_unit.sv
module tb_pgxlat_unit;
   localparam int VA_W    = 14;
   localparam int OFF_W   = 11;
   localparam int FRAME_W = 8;
   localparam int TLB_N   = 4;
   localparam int MADDR_W = 8;
   localparam int VPN_W   = VA_W - OFF_W;
   localparam int NPAGE   = 1 << VPN_W;
   localparam int PTE_W   = FRAME_W + 2;
   localparam int PA_W    = FRAME_W + OFF_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tbase_we = 1'b0;
   logic [MADDR_W-1:0] tbase_wdata = '0;
   logic tlen_we = 1'b0;
   logic [VPN_W:0] tlen_wdata = '0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [VA_W-1:0] req_addr = '0;
   logic req_write = 1'b0;
   logic rsp_valid;
   logic [1:0] rsp_fault;
   logic [PA_W-1:0] rsp_paddr;
   logic mem_valid;
   logic mem_ready = 1'b0;
   logic [MADDR_W-1:0] mem_addr;
   logic [PTE_W-1:0] mem_rdata;
   logic [NPAGE-1:0] page_mod;

   always #5 clk = ~clk;

   pgxlat_unit #(
      .VA_W(VA_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W), .TLB_N(TLB_N), .MADDR_W(MADDR_W)
   ) dut (
      .clk(clk), .rst_n(rst_n),
      .tbase_we(tbase_we), .tbase_wdata(tbase_wdata),
      .tlen_we(tlen_we), .tlen_wdata(tlen_wdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .page_mod(page_mod)
   );

   // page-table memory
   logic [PTE_W-1:0] pt_mem [256];
   assign mem_rdata = pt_mem[mem_addr];
   int lat_cnt = 0;
   int reads = 0;
   int cyc = 0;
   int last_hs = -10;
   logic [MADDR_W-1:0] last_addr = '0;

   always @(negedge clk) begin
      if (!mem_valid) begin
         mem_ready <= 1'b0;
         lat_cnt   <= $urandom % 4;
      end else if (!mem_ready) begin
         if (lat_cnt == 0) mem_ready <= 1'b1;
         else lat_cnt <= lat_cnt - 1;
      end
   end

   always @(posedge clk) begin
      if (mem_valid && mem_ready) begin
         reads     = reads + 1;
         last_hs   = cyc;
         last_addr = mem_addr;
      end
      cyc = cyc + 1;
   end

   // bench model
   logic [MADDR_W-1:0] m_base = '0;
   logic [VPN_W:0]     m_len = '0;
   logic               tv [TLB_N];
   logic [VPN_W-1:0]   tt [TLB_N];
   logic [FRAME_W-1:0] tf [TLB_N];
   logic               tw [TLB_N];
   int                 m_rr = 0;
   logic [NPAGE-1:0]   m_mod = '0;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   task automatic chk(input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic set_base(input logic [MADDR_W-1:0] v);
      @(negedge clk);
      tbase_we = 1'b1; tbase_wdata = v;
      @(negedge clk);
      tbase_we = 1'b0;
      m_base = v; m_rr = 0; m_mod = '0;
      for (int i = 0; i < TLB_N; i++) tv[i] = 1'b0;
   endtask

   task automatic set_len(input logic [VPN_W:0] v);
      @(negedge clk);
      tlen_we = 1'b1; tlen_wdata = v;
      @(negedge clk);
      tlen_we = 1'b0;
      m_len = v;
   endtask

   task automatic access(input logic [VA_W-1:0] a, input bit wr, input string tag);
      logic [VPN_W-1:0] vpn;
      logic [OFF_W-1:0] off;
      logic [PTE_W-1:0] pte;
      logic [MADDR_W-1:0] eaddr;
      int hit_i, r0, n;
      bit eread;
      logic [1:0] ef;
      logic [PA_W-1:0] ep;
      vpn = a[VA_W-1:OFF_W];
      off = a[OFF_W-1:0];
      eread = 0; ef = 2'd0; ep = '0; hit_i = -1;
      eaddr = m_base + MADDR_W'(vpn);
      if ({1'b0, vpn} >= m_len) begin
         ef = 2'd1;
      end else begin
         for (int i = 0; i < TLB_N; i++) if (tv[i] && tt[i] == vpn) hit_i = i;
         if (hit_i >= 0) begin
            ef = (wr && !tw[hit_i]) ? 2'd3 : 2'd0;
            ep = {tf[hit_i], off};
         end else begin
            eread = 1;
            pte = pt_mem[eaddr];
            if (!pte[FRAME_W]) ef = 2'd2;
            else if (wr && !pte[FRAME_W+1]) ef = 2'd3;
            else begin
               tv[m_rr] = 1'b1; tt[m_rr] = vpn; tf[m_rr] = pte[FRAME_W-1:0];
               tw[m_rr] = pte[FRAME_W+1];
               m_rr = (m_rr + 1) % TLB_N;
            end
            ep = {pte[FRAME_W-1:0], off};
         end
      end
      if (ef != 2'd0) ep = '0;
      if (ef == 2'd0 && wr) m_mod[vpn] = 1'b1;

      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = wr;
      r0 = reads;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      while (!rsp_valid && n < 60) begin
         @(negedge clk);
         n++;
      end
      chk($sformatf("%s response arrives R4", tag), rsp_valid, 1);
      chk($sformatf("%s fault code R5 R6 R7", tag), rsp_fault, ef);
      chk($sformatf("%s physical address R2", tag), rsp_paddr, ep);
      chk($sformatf("%s memory reads R8", tag), reads - r0, eread);
      if (eread) begin
         chk($sformatf("%s entry address R3", tag), last_addr, eaddr);
         chk($sformatf("%s miss latency R4", tag), last_hs, cyc - 1);
      end else begin
         chk($sformatf("%s hit latency R4", tag), n, 0);
      end
      chk($sformatf("%s modified flags R11", tag), page_mod, m_mod);
   endtask

   function automatic logic [VA_W-1:0] va(input int pg, input int off);
      return {VPN_W'(pg), OFF_W'(off)};
   endfunction

   initial begin
      int seed;
      seed = $urandom(32'h5EED_0042);
      for (int i = 0; i < 256; i++) pt_mem[i] = '0;
      for (int i = 0; i < TLB_N; i++) tv[i] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("reset req_ready R1", req_ready, 1);
      chk("reset rsp_valid R1", rsp_valid, 0);
      chk("reset mem_valid R1", mem_valid, 0);
      chk("reset page_mod R1", page_mod, 0);
      access(va(0, 5), 0, "reset length zero R1");

      // table at 0x20: pages 0..7
      for (int p = 0; p < NPAGE; p++)
         pt_mem[8'h20 + p] = {1'b1, 1'b1, 8'(8'h40 + p)};
      pt_mem[8'h22] = {1'b1, 1'b0, 8'h17};   // absent page 2
      pt_mem[8'h23] = {1'b0, 1'b1, 8'h33};   // read-only page 3
      set_base(8'h20);
      set_len(4'd8);

      access(va(1, 11'h123), 0, "miss R4");
      access(va(1, 11'h7FF), 0, "hit R4");
      access(va(1, 11'h000), 1, "write hit R11");
      access(va(2, 11'h010), 0, "absent R6");
      access(va(2, 11'h010), 0, "absent again R8");
      access(va(3, 11'h055), 1, "write ro miss R7");
      access(va(3, 11'h055), 0, "read ro R7");
      access(va(3, 11'h056), 1, "write ro hit R12");
      access(va(0, 11'h001), 1, "write miss R11");

      // round robin: slots hold 1,3,0 ; fill 4,5 -> 1 evicted
      access(va(4, 0), 0, "fill R10");
      access(va(5, 0), 0, "evict R10");
      access(va(3, 1), 0, "still cached R10");
      access(va(1, 2), 0, "evicted page R10");

      set_len(4'd3);
      access(va(3, 7), 0, "at length R5");
      access(va(2, 7), 0, "below length R5");
      access(va(7, 7), 1, "beyond length R5");
      set_len(4'd8);

      set_base(8'h20);
      access(va(1, 9), 0, "after flush R9");
      access(va(1, 9), 0, "refilled R9");

      // random phase
      for (int p = 0; p < 256; p++) begin
         logic [1:0] k;
         k = 2'($urandom % 4);
         pt_mem[p] = {(k != 2'd0), ($urandom % 8) != 0, 8'($urandom)};
      end
      set_base(8'($urandom));
      for (int it = 0; it < 500; it++) begin
         int r;
         r = $urandom % 100;
         if (r < 3) set_base(8'($urandom));
         else if (r < 6) set_len(4'($urandom % (NPAGE + 1)));
         access(VA_W'($urandom), bit'($urandom % 2), "random R2");
      end

      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog R4: actual=hung expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule